// File: doc/BRIEF.md
# Two-Phase Polar Successive Cancellation Decoder

This block decodes one polar codeword of length N with successive cancellation (SC). It views the codeword as a square array with side S = √N. For every outer index a (0 to S-1), a column phase runs first. It works out the likelihood of row a of the intermediate array for each column in turn. A row phase then decodes the S information positions of that row. Both phases use the same length-S core. The core holds its inputs in flip-flops and recomputes its whole likelihood tree for every leaf. No intermediate likelihood or partial sum is kept from one decoding step to the next.

Before a decode, the user loads the N channel LLRs through a write port. The user then presents a frozen-position mask and pulses `start`. The channel LLRs sit in S lane memories, one per array row, that can map onto block RAM. The intermediate row decisions are kept in an N-bit register store. When decoding finishes, `done` pulses for one cycle and `dec_bits` holds the decided bit for every position u[0..N-1]. N must be an even power of two; the default is N = 16, a 4×4 array.

Top module: `polar_tp_dec`

## Requirements
- R1: `dec_bits` equals the result of a full-length SC decoder. That decoder uses the natural-order generator F^{⊗log2 N} with F = [[1,0],[1,1]]. At every tree node the first half of the node's LLRs is `a` and the second half is `b`. The left child gets f(a,b) = sign(a)·sign(b)·min(|a|,|b|). The right child gets g = b + a when the partial-sum bit is 0 and b − a when it is 1. A positive LLR favours bit 0.
- R2: Every position whose bit in the captured frozen mask is 1 decodes to 0, whatever the LLRs are.
- R3: A non-frozen position decodes to 1 exactly when its leaf LLR is negative; a leaf LLR of zero gives 0.
- R4: LLRs are 6-bit two's complement values. Every f and g result is clipped to the range [−32, 31].
- R5: `done` is high for exactly one cycle. It rises S·(4S+2) clock edges after the edge that accepts `start`, which is 72 for N = 16.
- R6: A `start` pulse during a decode is ignored. It does not restart the decode, it does not change when `done` rises, and it does not change the result.
- R7: The frozen mask is sampled on the edge that accepts `start`. Changes to the `frozen` input during a decode have no effect on the result.
- R8: While the block is idle, `dec_bits` keeps its value, even if `frozen` changes or LLRs are written.
- R9: A write with `llr_we` high while idle stores `llr_data` as the channel LLR of codeword position `llr_addr`. A write during a decode is ignored.
- R10: After a synchronous reset, `done` is 0, `dec_bits` is all zero and the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted only while idle |
| frozen | input | N | Frozen-position mask, bit i = 1 freezes u[i] |
| llr_we | input | 1 | Channel LLR write enable |
| llr_addr | input | log2 N | Codeword position to write |
| llr_data | input | 6 | Channel LLR, two's complement |
| done | output | 1 | One-cycle completion pulse |
| dec_bits | output | N | Decoded bits u[0..N-1], registered |

## Verification
Random noisy codewords under random frozen masks are decoded and compared, bit for bit, with a full-length SC model written in the bench. A design that mixed up partial sums between the column and row phases, or that read the wrong column, would disagree with that model on almost every word. Directed cases cover all-zero LLRs, all-frozen masks and inputs pinned at −32 and +31. These catch a tie that is decided as 1, a frozen bit that leaks a hard decision, and a clip that wraps or is asymmetric. During a run the bench also injects a second start, flips the mask and writes an LLR. A design that restarted, sampled the mask late or let the write through would show a shifted `done` or a wrong word.

// File: rtl/polar_tp_pkg.sv
package polar_tp_pkg;
  localparam int LLR_W = 6;
  localparam int EXT_W = LLR_W + 2;

  typedef logic signed [LLR_W-1:0] llr_t;
  typedef logic signed [EXT_W-1:0] ext_t;

  localparam ext_t LLR_MAX = ext_t'((1 << (LLR_W - 1)) - 1);
  localparam ext_t LLR_MIN = ext_t'(-(1 << (LLR_W - 1)));

  function automatic llr_t llr_clip(input ext_t x);
    if (x > LLR_MAX) return llr_t'(LLR_MAX);
    if (x < LLR_MIN) return llr_t'(LLR_MIN);
    return llr_t'(x);
  endfunction

  // min-sum check-node update
  function automatic llr_t f_minsum(input llr_t a, input llr_t b);
    ext_t ma, mb, m;
    ma = (a < 0) ? -ext_t'(a) : ext_t'(a);
    mb = (b < 0) ? -ext_t'(b) : ext_t'(b);
    m  = (ma < mb) ? ma : mb;
    return llr_clip((a[LLR_W-1] ^ b[LLR_W-1]) ? -m : m);
  endfunction

  // variable-node update steered by the partial sum
  function automatic llr_t g_combine(input llr_t a, input llr_t b, input logic p);
    return llr_clip(p ? (ext_t'(b) - ext_t'(a)) : (ext_t'(b) + ext_t'(a)));
  endfunction
endpackage

// File: rtl/polar_tp_lane_ram.sv
module polar_tp_lane_ram
  import polar_tp_pkg::*;
#(
  parameter  int SIDE = 4,
  localparam int AW   = $clog2(SIDE)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wlane,
  input  logic [AW-1:0] waddr,
  input  llr_t          wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output llr_t          rdata [SIDE]
);
  // one simple dual-port memory per array row; a read returns a whole column
  for (genvar j = 0; j < SIDE; j++) begin : g_lane
    llr_t mem [SIDE];
    llr_t rd_q;
    always_ff @(posedge clk) begin
      if (we && (wlane == AW'(j))) mem[waddr] <= wdata;
      if (re) rd_q <= mem[raddr];
    end
    assign rdata[j] = rd_q;
  end
endmodule

// File: rtl/polar_tp_core.sv
module polar_tp_core
  import polar_tp_pkg::*;
#(
  parameter  int SIDE = 4,
  localparam int M    = $clog2(SIDE)
) (
  input  logic            clk,
  input  logic            load,
  input  llr_t            llr_in [SIDE],
  input  logic [SIDE-1:0] bits_in,
  input  logic            set_en,
  input  logic [M-1:0]    set_idx,
  input  logic            set_val,
  input  logic [M-1:0]    leaf,
  output llr_t            leaf_llr,
  output logic [SIDE-1:0] part_enc
);
  typedef logic [M-1:0] idx_t;

  llr_t            llr_q [SIDE];
  logic [SIDE-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (load) begin
      llr_q  <= llr_in;
      bits_q <= bits_in;
    end else if (set_en) begin
      bits_q[set_idx] <= set_val;
    end
  end

  // polar transform of a bit vector (u times the Kronecker power of F)
  function automatic logic [SIDE-1:0] polar_xform(input logic [SIDE-1:0] v);
    logic [SIDE-1:0] r;
    r = v;
    for (int st = 0; st < M; st++)
      for (int t = 0; t < SIDE; t++)
        if (((t >> st) & 1) == 0) r[idx_t'(t)] = r[idx_t'(t)] ^ r[idx_t'(t | (1 << st))];
    return r;
  endfunction

  // walks the tree from the root to one leaf, recomputing every node on the way
  function automatic llr_t leaf_eval(input llr_t v_in [SIDE], input logic [SIDE-1:0] u,
                                     input idx_t idx);
    llr_t            w [SIDE];
    logic [SIDE-1:0] sub, ps;
    logic            right;
    int              len, half, base;
    w = v_in;
    for (int lv = 0; lv < M; lv++) begin
      len   = SIDE >> lv;
      half  = len / 2;
      base  = int'(idx) & ~(len - 1);
      right = |((idx >> (M - 1 - lv)) & idx_t'(1));
      for (int t = 0; t < SIDE; t++)
        sub[idx_t'(t)] = (t < half) ? u[idx_t'(base + t)] : 1'b0;
      ps = polar_xform(sub);
      for (int t = 0; t < SIDE; t++)
        if (t < half)
          w[idx_t'(t)] = right ? g_combine(w[idx_t'(t)], w[idx_t'(t + half)], ps[idx_t'(t)])
                               : f_minsum(w[idx_t'(t)], w[idx_t'(t + half)]);
    end
    return w[0];
  endfunction

  always_comb begin
    leaf_llr = leaf_eval(llr_q, bits_q, leaf);
    part_enc = polar_xform(bits_q);
  end
endmodule

// File: rtl/polar_tp_dec.sv
module polar_tp_dec
  import polar_tp_pkg::*;
#(
  parameter  int N     = 16,
  localparam int LOG_N = $clog2(N),
  localparam int M     = LOG_N / 2,
  localparam int SIDE  = 1 << M
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [N-1:0]     frozen,
  input  logic             llr_we,
  input  logic [LOG_N-1:0] llr_addr,
  input  logic [LLR_W-1:0] llr_data,
  output logic             done,
  output logic [N-1:0]     dec_bits
);
  typedef logic [M-1:0] idx_t;
  typedef enum logic [2:0] {
    ST_IDLE, ST_COL_RD, ST_COL_LD, ST_COL_EV, ST_ROW_LD, ST_ROW_DEC, ST_ROW_WB
  } state_t;

  state_t          st_q;
  idx_t            a_q, k_q;
  logic [N-1:0]    frz_q;
  logic [SIDE-1:0] w_q [SIDE];
  llr_t            lam_q [SIDE];
  llr_t            ram_rd [SIDE];
  llr_t            core_in [SIDE];
  logic [SIDE-1:0] core_bits, col_bits, part_enc;
  logic            core_load, set_en, dec_bit, busy, last_k, last_a;
  idx_t            leaf_idx;
  llr_t            leaf_llr;

  assign busy   = (st_q != ST_IDLE);
  assign last_k = (k_q == idx_t'(SIDE - 1));
  assign last_a = (a_q == idx_t'(SIDE - 1));

  polar_tp_lane_ram #(.SIDE(SIDE)) u_ram (
    .clk   (clk),
    .we    (llr_we && !busy),
    .wlane (llr_addr[LOG_N-1 -: M]),
    .waddr (llr_addr[M-1:0]),
    .wdata (llr_t'(llr_data)),
    .re    (st_q == ST_COL_RD),
    .raddr (k_q),
    .rdata (ram_rd)
  );

  // column phase: channel column k with decided rows; row phase: column results
  always_comb begin
    for (int j = 0; j < SIDE; j++) col_bits[idx_t'(j)] = w_q[idx_t'(j)][k_q];
    for (int j = 0; j < SIDE; j++)
      core_in[idx_t'(j)] = (st_q == ST_ROW_LD) ? lam_q[idx_t'(j)] : ram_rd[idx_t'(j)];
    core_bits = (st_q == ST_ROW_LD) ? '0 : col_bits;
    core_load = (st_q == ST_COL_LD) || (st_q == ST_ROW_LD);
    set_en    = (st_q == ST_ROW_DEC);
    leaf_idx  = (st_q == ST_ROW_DEC) ? k_q : a_q;
    dec_bit   = frz_q[{a_q, k_q}] ? 1'b0 : leaf_llr[LLR_W-1];
  end

  polar_tp_core #(.SIDE(SIDE)) u_core (
    .clk      (clk),
    .load     (core_load),
    .llr_in   (core_in),
    .bits_in  (core_bits),
    .set_en   (set_en),
    .set_idx  (k_q),
    .set_val  (dec_bit),
    .leaf     (leaf_idx),
    .leaf_llr (leaf_llr),
    .part_enc (part_enc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      a_q      <= '0;
      k_q      <= '0;
      frz_q    <= '0;
      done     <= 1'b0;
      dec_bits <= '0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start) begin
          frz_q <= frozen;
          a_q   <= '0;
          k_q   <= '0;
          st_q  <= ST_COL_RD;
        end
        ST_COL_RD: st_q <= ST_COL_LD;
        ST_COL_LD: st_q <= ST_COL_EV;
        ST_COL_EV: begin
          k_q  <= last_k ? '0 : k_q + 1'b1;
          st_q <= last_k ? ST_ROW_LD : ST_COL_RD;
        end
        ST_ROW_LD: st_q <= ST_ROW_DEC;
        ST_ROW_DEC: begin
          dec_bits[{a_q, k_q}] <= dec_bit;
          k_q  <= last_k ? '0 : k_q + 1'b1;
          if (last_k) st_q <= ST_ROW_WB;
        end
        ST_ROW_WB: begin
          if (last_a) begin
            done <= 1'b1;
            st_q <= ST_IDLE;
          end else begin
            a_q  <= a_q + 1'b1;
            st_q <= ST_COL_RD;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // datapath stores, no reset needed
  always_ff @(posedge clk) begin
    if (st_q == ST_COL_EV) lam_q[k_q] <= leaf_llr;
    if (st_q == ST_ROW_WB) w_q[a_q] <= part_enc;
  end
endmodule

// File: rtl/polar_tp_dec_chk.sv
module polar_tp_dec_chk #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [N-1:0] frz_q,
  input logic [N-1:0] dec_bits
);
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_frozen_zero_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> ((dec_bits & frz_q) == '0));

  assert_restart_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done));

  assert_mask_held_R7: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(frz_q));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !done) |=> $stable(dec_bits));
endmodule

bind polar_tp_dec polar_tp_dec_chk #(.N(N)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .frz_q    (frz_q),
  .dec_bits (dec_bits)
);

// File: tb/tb_polar_tp_dec.sv
`timescale 1ns/1ps
module tb_polar_tp_dec;
  import polar_tp_pkg::*;

  localparam int N    = 16;
  localparam int LOGN = 4;
  localparam int SIDE = 4;
  localparam int LAT  = SIDE * (4 * SIDE + 2);

  logic            clk = 1'b0;
  logic            rst, start, llr_we, done;
  logic [N-1:0]    frozen, dec_bits;
  logic [LOGN-1:0] llr_addr;
  logic [LLR_W-1:0] llr_data;

  int           n_chk = 0, n_fail = 0;
  int           ch [N];
  logic [N-1:0] frz_v, ref_u, u_src;

  always #2.5 clk = ~clk;

  polar_tp_dec #(.N(N)) dut (
    .clk(clk), .rst(rst), .start(start), .frozen(frozen), .llr_we(llr_we),
    .llr_addr(llr_addr), .llr_data(llr_data), .done(done), .dec_bits(dec_bits)
  );

  task automatic check(input bit ok, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic int rsat(input int x);
    return (x > 31) ? 31 : ((x < -32) ? -32 : x);
  endfunction
  function automatic int rf(input int a, input int b);
    int ma, mb, m;
    ma = (a < 0) ? -a : a;
    mb = (b < 0) ? -b : b;
    m  = (ma < mb) ? ma : mb;
    return rsat(((a < 0) != (b < 0)) ? -m : m);
  endfunction
  function automatic int rg(input int a, input int b, input bit p);
    return rsat(p ? b - a : b + a);
  endfunction
  function automatic logic [N-1:0] rxform(input logic [N-1:0] v);
    logic [N-1:0] r;
    r = v;
    for (int st = 0; st < LOGN; st++)
      for (int t = 0; t < N; t++)
        if (((t >> st) & 1) == 0) r[t] = r[t] ^ r[t + (1 << st)];
    return r;
  endfunction

  // full-length SC model over all N positions
  task automatic ref_decode();
    for (int i = 0; i < N; i++) begin
      int w [N];
      logic [N-1:0] sub, ps;
      int len, half, base;
      bit right;
      for (int t = 0; t < N; t++) w[t] = ch[t];
      for (int lv = 0; lv < LOGN; lv++) begin
        len   = N >> lv;
        half  = len / 2;
        base  = i & ~(len - 1);
        right = ((i >> (LOGN - 1 - lv)) & 1) != 0;
        sub   = '0;
        for (int t = 0; t < half; t++) sub[t] = ref_u[base + t];
        ps = rxform(sub);
        for (int t = 0; t < half; t++)
          w[t] = right ? rg(w[t], w[t + half], ps[t]) : rf(w[t], w[t + half]);
      end
      ref_u[i] = frz_v[i] ? 1'b0 : (w[0] < 0);
    end
  endtask

  task automatic make_noisy(input int amp, input int noise);
    logic [N-1:0] x;
    u_src = N'({$urandom, $urandom}) & ~frz_v;
    x = rxform(u_src);
    for (int i = 0; i < N; i++)
      ch[i] = rsat((x[i] ? -amp : amp) + int'($urandom_range(2 * noise, 0)) - noise);
  endtask

  // mode bit0: second start mid-run, bit1: mask flip mid-run, bit2: LLR write mid-run
  task automatic run_case(input string tag, input int mode);
    int cyc;
    ref_decode();
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      llr_we = 1'b1; llr_addr = LOGN'(i); llr_data = LLR_W'(ch[i]);
    end
    @(negedge clk);
    llr_we = 1'b0; frozen = frz_v; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    cyc = 0;
    while (cyc < 4 * LAT) begin
      @(posedge clk); #1;
      cyc++;
      if (done) break;
      start  = ((mode & 1) != 0) && (cyc == 10);
      llr_we = ((mode & 4) != 0) && (cyc == 7);
      llr_addr = '0;
      llr_data = (ch[0] < 0) ? LLR_W'(31) : LLR_W'(-32);
      if (((mode & 2) != 0) && (cyc == 5)) frozen = ~frz_v;
    end
    start = 1'b0; llr_we = 1'b0;
    check(cyc == LAT, $sformatf("R5/R6 %s latency actual=%0d expected=%0d", tag, cyc, LAT));
    check(dec_bits == ref_u,
          $sformatf("R1 %s bits actual=%h expected=%h", tag, dec_bits, ref_u));
    check((dec_bits & frz_v) == '0,
          $sformatf("R2 %s frozen bits actual=%h expected=0", tag, dec_bits & frz_v));
    @(posedge clk); #1;
    check(done == 1'b0, $sformatf("R5 %s done width actual=%0b expected=0", tag, done));
    frozen = frz_v;
  endtask

  initial begin
    #(100000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [N-1:0] snap;
    void'($urandom(32'd2024));
    rst = 1'b1; start = 1'b0; llr_we = 1'b0; llr_addr = '0; llr_data = '0; frozen = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    check(done == 1'b0, $sformatf("R10 reset done actual=%0b expected=0", done));
    check(dec_bits == '0, $sformatf("R10 reset bits actual=%h expected=0", dec_bits));

    // R3: zero LLRs everywhere give zero leaf LLRs, ties decide 0
    frz_v = '0;
    for (int i = 0; i < N; i++) ch[i] = 0;
    run_case("R3 zero-llr", 0);
    check(dec_bits == '0, $sformatf("R3 tie actual=%h expected=0", dec_bits));

    // R2: all positions frozen with strongly negative LLRs
    frz_v = '1;
    for (int i = 0; i < N; i++) ch[i] = -20;
    run_case("R2 all-frozen", 0);
    check(dec_bits == '0, $sformatf("R2 all frozen actual=%h expected=0", dec_bits));

    // R4: saturated inputs
    frz_v = '0;
    for (int i = 0; i < N; i++) ch[i] = -32;
    run_case("R4 all-min", 0);
    for (int i = 0; i < N; i++) ch[i] = (i % 3 == 0) ? 31 : -32;
    frz_v = 16'h0107;
    run_case("R4 mixed-extreme", 0);

    // R9: position-specific LLRs, noiseless codeword
    frz_v = 16'h0117;
    u_src = 16'h8c40 & ~frz_v;
    snap  = rxform(u_src);
    for (int i = 0; i < N; i++) ch[i] = snap[i] ? -(i + 3) : (i + 3);
    run_case("R9 map", 0);

    // R6, R7, R9: disturbances during a decode
    frz_v = 16'h0a13; make_noisy(8, 9);
    run_case("R6 restart", 1);
    frz_v = 16'h1317; make_noisy(8, 9);
    run_case("R7 mask-flip", 2);
    frz_v = 16'h0013; make_noisy(8, 9);
    run_case("R9 busy-write", 4);

    // R8: idle activity does not touch the result
    snap = dec_bits;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      frozen = N'($urandom); llr_we = 1'b1; llr_addr = LOGN'($urandom); llr_data = LLR_W'($urandom);
    end
    @(negedge clk); llr_we = 1'b0;
    check(dec_bits == snap, $sformatf("R8 idle hold actual=%h expected=%h", dec_bits, snap));

    // R1: random noisy words and masks
    for (int r = 0; r < 25; r++) begin
      frz_v = N'($urandom) & N'($urandom);
      make_noisy(int'($urandom_range(12, 4)), int'($urandom_range(14, 2)));
      run_case($sformatf("R1 random%0d", r), 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule